// File: doc/BRIEF.md
# Programmable Sum-of-Products Logic Plane

This block is the logic plane of a small programmable logic device. Fourteen dedicated inputs and twelve feedback signals each enter the plane in true and inverted form, which gives fifty-two columns. Every product-term row ANDs the columns it is connected to. A fixed OR stage then folds groups of rows into twelve output sums. The outputs do not all get the same number of rows: the outer outputs get 8 rows and the middle ones get up to 16.

The same array produces one enable term for each output. It also produces two global terms, a synchronous preset and an asynchronous reset, which the macrocells downstream use. From its inputs to its outputs the block is purely combinational. The only state is the connection pattern. It can be written one whole row at a time through a parallel port, or shifted in one bit per cycle through a serial chain. The two dedicated inputs that also act as clock pins are treated in the plane exactly like the other inputs.

Top module: `pt_logic_plane`

## Requirements
- R1: While `rst_n` is low, every connection cell is cleared. With no cell connected, every output (`sum_o`, `oe_o`, `preset_o`, `areset_o`) reads 1.
- R2: Signal k is `in_i[k]` for k from 0 to 13 and `fb_i[k-14]` for k from 14 to 25. Its true form drives column 2k and its inverted form drives column 2k+1. Bit c of a row word connects column c.
- R3: A row evaluates to the AND of the columns it connects. A row with no connected columns evaluates to 1.
- R4: A row that connects both the true and the inverted column of the same signal always evaluates to 0.
- R5: Output j ORs only its own block of consecutive rows. The block sizes for outputs 0 to 11 are 8, 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, 8, so the blocks start at rows 0, 8, 16, 26, 38, 52, 68, 84, 98, 110, 120, 128.
- R6: Row 136+j drives `oe_o[j]`, row 148 drives `preset_o`, and row 149 drives `areset_o`.
- R7: When `cfg_wr` is high at a clock edge, `cfg_row` replaces the row at `cfg_addr`. A write to an address of 150 or above changes nothing.
- R8: When `cfg_shift` is high (and `cfg_wr` is low) at a clock edge, the whole pattern shifts by one bit. `cfg_sdi` enters bit 0 of row 0, each bit moves one position up, and bit 51 of row r moves to bit 0 of row r+1. When `cfg_wr` and `cfg_shift` are high together, only the write happens.
- R9: When neither `cfg_wr` nor `cfg_shift` is high, the pattern holds.
- R10: The outputs follow `in_i` and `fb_i` within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration store |
| rst_n | input | 1 | Active-low asynchronous clear of the pattern |
| in_i | input | 14 | Dedicated inputs |
| fb_i | input | 12 | Feedback signals from the macrocells |
| cfg_wr | input | 1 | Parallel row write strobe |
| cfg_addr | input | 8 | Row index for the parallel write |
| cfg_row | input | 52 | Row word; bit c connects column c |
| cfg_shift | input | 1 | Serial shift strobe |
| cfg_sdi | input | 1 | Serial data into the chain |
| sum_o | output | 12 | OR of each output's row block |
| oe_o | output | 12 | Per-output enable terms |
| preset_o | output | 1 | Shared synchronous preset term |
| areset_o | output | 1 | Shared asynchronous reset term |

## Verification
A wrong connection bit appears on an output as soon as the input pattern exercises that column. It shows in the same cycle, so the test programs rows whose terms depend on single, known columns and then walks input patterns that turn each term on and off. A row assigned to the wrong output group shows up as a sum that follows a term from a neighbouring block. The test therefore places terms on the first and last row of several blocks. Faults in the write or shift path show one cycle after the edge that loaded the pattern, and they appear as enable or global terms that follow the wrong input.

// File: rtl/pt_logic_plane.sv
module pt_logic_plane #(
  parameter int N_IN = 14,
  parameter int N_OUT = 12,
  parameter int CW = 5,
  parameter logic [N_OUT*CW-1:0] TERMS = {5'd8, 5'd8, 5'd10, 5'd12, 5'd14, 5'd16,
                                          5'd16, 5'd14, 5'd12, 5'd10, 5'd8, 5'd8},
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_IN-1:0]             in_i,
  input  logic [N_OUT-1:0]            fb_i,
  input  logic                        cfg_wr,
  input  logic [ADDR_W-1:0]           cfg_addr,
  input  logic [2*(N_IN+N_OUT)-1:0]   cfg_row,
  input  logic                        cfg_shift,
  input  logic                        cfg_sdi,
  output logic [N_OUT-1:0]            sum_o,
  output logic [N_OUT-1:0]            oe_o,
  output logic                        preset_o,
  output logic                        areset_o
);
  function automatic int cnt_of(int j);
    return int'(TERMS[j*CW +: CW]);
  endfunction

  function automatic int base_of(int j);
    int b = 0;
    for (int i = 0; i < j; i++) b += cnt_of(i);
    return b;
  endfunction

  localparam int N_SIG  = N_IN + N_OUT;
  localparam int N_COLS = 2 * N_SIG;
  localparam int N_SUM  = base_of(N_OUT);
  localparam int N_ROWS = N_SUM + N_OUT + 2;

  logic [N_COLS-1:0] cfg_q [N_ROWS];
  logic [N_SIG-1:0]  sig;
  logic [N_COLS-1:0] col;
  logic [N_ROWS-1:0] term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_ROWS; r++) cfg_q[r] <= '0;
    end else if (cfg_wr) begin
      if (int'(cfg_addr) < N_ROWS) cfg_q[cfg_addr] <= cfg_row;
    end else if (cfg_shift) begin
      cfg_q[0] <= {cfg_q[0][N_COLS-2:0], cfg_sdi};
      for (int r = 1; r < N_ROWS; r++)
        cfg_q[r] <= {cfg_q[r][N_COLS-2:0], cfg_q[r-1][N_COLS-1]};
    end
  end

  assign sig = {fb_i, in_i};

  for (genvar k = 0; k < N_SIG; k++) begin : g_col
    assign col[2*k]   = sig[k];
    assign col[2*k+1] = ~sig[k];
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign term[r] = &(~cfg_q[r] | col);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_sum
    localparam int B = base_of(j);
    localparam int W = cnt_of(j);
    assign sum_o[j] = |term[B +: W];
  end

  assign oe_o     = term[N_SUM +: N_OUT];
  assign preset_o = term[N_SUM + N_OUT];
  assign areset_o = term[N_SUM + N_OUT + 1];

  a_r7_row_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && int'(cfg_addr) < N_ROWS) |=> cfg_q[$past(cfg_addr)] == $past(cfg_row));

  a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shift && !cfg_wr) |=> cfg_q[0][0] == $past(cfg_sdi));

  a_r8_chain_link: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_shift && !cfg_wr) |=> cfg_q[1][0] == $past(cfg_q[0][N_COLS-1]));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wr && !cfg_shift) |=> ($stable(cfg_q[0]) && $stable(cfg_q[N_ROWS-1])));

  a_r4_contradict_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[N_ROWS-1][1:0] == 2'b11) |-> !areset_o);

  a_r3_blank_high: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[N_ROWS-2] == '0) |-> preset_o);
endmodule

// File: tb/test_pt_logic_plane.sv
module test_pt_logic_plane;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] in_i = '0;
  logic [11:0] fb_i = '0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [51:0] cfg_row = '0;
  logic cfg_shift = 1'b0;
  logic cfg_sdi = 1'b0;
  logic [11:0] sum_o, oe_o;
  logic preset_o, areset_o;
  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  pt_logic_plane i_pt_logic_plane (
    .clk(clk), .rst_n(rst_n), .in_i(in_i), .fb_i(fb_i),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_row(cfg_row),
    .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
    .sum_o(sum_o), .oe_o(oe_o), .preset_o(preset_o), .areset_o(areset_o));

  // {in[13:0], fb[11:0], sum[11:0], oe[11:0], preset, areset}
  localparam logic [51:0] VEC [7] = '{
    {14'h0000, 12'h000, 12'h802, 12'h001, 1'b0, 1'b1},
    {14'h3FFF, 12'hFFF, 12'h021, 12'h801, 1'b1, 1'b0},
    {14'h000C, 12'h000, 12'h822, 12'h001, 1'b0, 1'b1},
    {14'h2000, 12'h000, 12'h842, 12'h001, 1'b0, 1'b0},
    {14'h2000, 12'h020, 12'h802, 12'h001, 1'b0, 1'b0},
    {14'h0013, 12'h801, 12'h021, 12'h801, 1'b1, 1'b1},
    {14'h0004, 12'h000, 12'h802, 12'h001, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [25:0] exp);
    logic [25:0] act;
    act = {sum_o, oe_o, preset_o, areset_o};
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got sum=%h oe=%h sp=%b ar=%b, expected sum=%h oe=%h sp=%b ar=%b",
               tag, act[25:14], act[13:2], act[1], act[0],
               exp[25:14], exp[13:2], exp[1], exp[0]);
    end
  endtask

  task automatic wr_row(input int addr, input logic [51:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'(addr); cfg_row = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic apply(input logic [13:0] a, input logic [11:0] b);
    @(negedge clk);
    in_i = a; fb_i = b;
    #1;
  endtask

  task automatic walk(input string tag);
    for (int v = 0; v < 7; v++) begin
      apply(VEC[v][51:38], VEC[v][37:26]);
      chk(tag, VEC[v][25:0]);
    end
  endtask

  initial begin
    #400000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 R3: cleared pattern, every term high
    apply(14'h0000, 12'h000);
    chk("R1 reset blank", {12'hFFF, 12'hFFF, 1'b1, 1'b1});
    apply(14'h3FFF, 12'hABC);
    chk("R1 R3 blank ignores inputs", {12'hFFF, 12'hFFF, 1'b1, 1'b1});
    rst_n = 1'b1;
    apply(14'h1234, 12'h567);
    chk("R9 after reset release", {12'hFFF, 12'hFFF, 1'b1, 1'b1});

    // R4: every row contradicts signal 0
    for (int r = 0; r < 150; r++) wr_row(r, 52'h3);
    apply(14'h0001, 12'h000);
    chk("R4 contradiction low", {12'h000, 12'h000, 1'b0, 1'b0});
    apply(14'h0000, 12'hFFF);
    chk("R4 contradiction low", {12'h000, 12'h000, 1'b0, 1'b0});

    // R2 R5 R6 R7: program specific rows
    wr_row(0,   52'h1);
    wr_row(15,  52'h8);
    wr_row(67,  52'h50);
    wr_row(52,  52'h1000_0000);
    wr_row(135, 52'h8_0000_0000_0000);
    wr_row(68,  52'h0080_0400_0000);
    wr_row(136, 52'h0);
    wr_row(147, 52'h100);
    wr_row(148, 52'h5);
    wr_row(149, 52'h800_0000);

    // R2 R3 R5 R6 R10 table walk
    walk("R2 R5 R6 R10 vector");

    // R7: out-of-range write changes nothing
    wr_row(200, 52'h0);
    wr_row(255, 52'h0);
    apply(14'h0000, 12'h000);
    chk("R7 out-of-range ignored", {12'h802, 12'h001, 1'b0, 1'b1});

    // R8: write wins over simultaneous shift
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'd0; cfg_row = 52'h1; cfg_shift = 1'b1; cfg_sdi = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_shift = 1'b0;
    apply(14'h0000, 12'h000);
    chk("R8 write beats shift", {12'h802, 12'h001, 1'b0, 1'b1});

    // R9: idle cycles hold the pattern
    repeat (20) @(negedge clk);
    walk("R9 hold vector");

    // R8: 52 shifts of zero move each row down by one
    @(negedge clk);
    cfg_shift = 1'b1; cfg_sdi = 1'b0;
    repeat (52) @(negedge clk);
    cfg_shift = 1'b0;
    apply(14'h0010, 12'h000);
    chk("R8 serial chain", {12'h005, 12'h003, 1'b1, 1'b0});
    apply(14'h0003, 12'h800);
    chk("R8 serial chain", {12'h001, 12'h002, 1'b0, 1'b1});

    // R1: asynchronous clear mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 clear mid-run", {12'hFFF, 12'hFFF, 1'b1, 1'b1});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule